// File: doc/BRIEF.md
# Leaf Interrupt Group Register Bank

This block is one leaf group in a two-level interrupt tree. It receives single-cycle event pulses on 32 source lines and records each one in a pending register, unless the matching mask bit blocks it. Software acknowledges pending bits by writing ones to them. An enable register is applied only when the group is summarised for the parent aggregator. The block drives three registered summary levels upstream: one for the whole word, one for the low half and one for the high half. With the two half outputs, a single group can feed two separate parent bits.

A plain register port gives access to four 32-bit registers. The port takes a word index, which is the byte offset from the group base divided by four:

| Byte offset | Word index | Register |
|---|---|---|
| 0x0 | 0 | status mirror |
| 0x4 | 1 | mask |
| 0x8 | 2 | pending |
| 0xC | 3 | enable |

The status mirror tracks the raw source levels. Reads are combinational from the addressed register, and writes take effect at the clock edge.

Top module: `intr_group_bank`

## Requirements
- R1: Word index 0 reads the status mirror, 1 the mask, 2 the pending register and 3 the enable register (byte offsets 0x0, 0x4, 0x8, 0xC). A read returns the register's current contents.
- R2: After reset, all four registers read zero and all three summary outputs are low.
- R3: An event pulse on line n with mask bit n at 0 sets pending bit n at the next clock edge.
- R4: An event pulse on line n with mask bit n at 1 leaves pending bit n unchanged. Clearing the mask afterwards does not make the dropped event appear.
- R5: A write to the pending register clears every pending bit whose written bit is 1. Pending bits whose written bit is 0 keep their value.
- R6: An event and a clear on the same pending bit in the same cycle leave that bit set.
- R7: A write to the mask or to the enable register replaces the whole register. An event in the same cycle as a mask write is gated by the mask value from before the write.
- R8: The summary output irq_any goes high one cycle after the AND of pending and enable becomes nonzero, and goes low one cycle after that AND becomes zero.
- R9: irq_lo follows the same rule as irq_any using bits 15:0 only. irq_hi follows it using bits 31:16 only.
- R10: The status mirror holds the source levels sampled at the previous clock edge. Writes to word index 0 have no effect.
- R11: The enable register does not affect latching. An unmasked event becomes pending even while its enable bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| evt_i | input | 32 | single-cycle event pulses, one per source |
| src_lvl_i | input | 32 | raw source levels mirrored into status |
| reg_we | input | 1 | write strobe for the register port |
| reg_idx | input | 2 | register word index (byte offset / 4) |
| reg_wdata | input | 32 | write data |
| reg_rdata | output | 32 | read data of the register selected by reg_idx |
| irq_any | output | 1 | registered summary over all bits |
| irq_lo | output | 1 | registered summary over bits 15:0 |
| irq_hi | output | 1 | registered summary over bits 31:16 |

## Verification
Two functions can fall in the same cycle on the same bit: an incoming event, and a software clear or mask update. The bench sets up this overlap on purpose, once with an event and a write-one clear to the same pending bit, and once with an event and a mask write in the same cycle. It then reads the pending register on the next cycle and expects the event to win the clear and to be gated by the old mask. The random phase uses dense event words and random writes to all four registers, so the same overlaps occur many more times. Each result is compared against a bench model that advances every register from the pre-edge state.

// File: rtl/igb_pkg.sv
package igb_pkg;
  // Register word index inside one group (byte offset >> 2).
  typedef enum logic [1:0] {
    SEL_STAT = 2'd0,
    SEL_MASK = 2'd1,
    SEL_PEND = 2'd2,
    SEL_ENAB = 2'd3
  } reg_sel_e;

  localparam int unsigned IDX_W = 2;
endpackage

// File: rtl/igb_pend_latch.sv
module igb_pend_latch #(
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] evt,
  input  logic [DW-1:0] mask,
  input  logic          clr_we,
  input  logic [DW-1:0] clr_bits,
  output logic [DW-1:0] pend
);
  logic [DW-1:0] clr_eff;
  logic [DW-1:0] set_eff;
  logic [DW-1:0] pend_nxt;

  always_comb begin
    clr_eff  = clr_we ? clr_bits : '0;
    set_eff  = evt & ~mask;
    // set dominates clear on a colliding bit
    pend_nxt = (pend & ~clr_eff) | set_eff;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pend <= '0;
    else        pend <= pend_nxt;
  end
endmodule

// File: rtl/igb_ctrl_regs.sv
module igb_ctrl_regs #(
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mask_we,
  input  logic          enab_we,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] src_lvl,
  output logic [DW-1:0] mask_q,
  output logic [DW-1:0] enab_q,
  output logic [DW-1:0] stat_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q <= '0;
      enab_q <= '0;
      stat_q <= '0;
    end else begin
      stat_q <= src_lvl;
      if (mask_we) mask_q <= wdata;
      if (enab_we) enab_q <= wdata;
    end
  end
endmodule

// File: rtl/igb_summary.sv
module igb_summary #(
  parameter int unsigned DW     = 32,
  parameter int unsigned SLICES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DW-1:0]     pend,
  input  logic [DW-1:0]     enab,
  output logic [SLICES-1:0] slice_irq,
  output logic              any_irq
);
  localparam int unsigned SW = DW / SLICES;

  logic [DW-1:0]     live;
  logic [SLICES-1:0] slice_nxt;

  assign live = pend & enab;

  for (genvar s = 0; s < SLICES; s++) begin : g_slice
    assign slice_nxt[s] = |live[s*SW +: SW];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slice_irq <= '0;
      any_irq   <= 1'b0;
    end else begin
      slice_irq <= slice_nxt;
      any_irq   <= |live;
    end
  end
endmodule

// File: rtl/intr_group_bank.sv
module intr_group_bank #(
  parameter int unsigned DW = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [DW-1:0]           evt_i,
  input  logic [DW-1:0]           src_lvl_i,
  input  logic                    reg_we,
  input  logic [igb_pkg::IDX_W-1:0] reg_idx,
  input  logic [DW-1:0]           reg_wdata,
  output logic [DW-1:0]           reg_rdata,
  output logic                    irq_any,
  output logic                    irq_lo,
  output logic                    irq_hi
);
  import igb_pkg::*;

  localparam int unsigned SLICES = 2;

  reg_sel_e      sel;
  logic [DW-1:0] imr_q, ier_q, iir_q, isr_q;
  logic [SLICES-1:0] slice_irq;

  assign sel = reg_sel_e'(reg_idx);

  igb_ctrl_regs #(.DW(DW)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .mask_we (reg_we && sel == SEL_MASK),
    .enab_we (reg_we && sel == SEL_ENAB),
    .wdata   (reg_wdata),
    .src_lvl (src_lvl_i),
    .mask_q  (imr_q),
    .enab_q  (ier_q),
    .stat_q  (isr_q)
  );

  igb_pend_latch #(.DW(DW)) u_pend (
    .clk      (clk),
    .rst_n    (rst_n),
    .evt      (evt_i),
    .mask     (imr_q),
    .clr_we   (reg_we && sel == SEL_PEND),
    .clr_bits (reg_wdata),
    .pend     (iir_q)
  );

  igb_summary #(.DW(DW), .SLICES(SLICES)) u_sum (
    .clk       (clk),
    .rst_n     (rst_n),
    .pend      (iir_q),
    .enab      (ier_q),
    .slice_irq (slice_irq),
    .any_irq   (irq_any)
  );

  assign irq_lo = slice_irq[0];
  assign irq_hi = slice_irq[1];

  always_comb begin
    unique case (sel)
      SEL_STAT: reg_rdata = isr_q;
      SEL_MASK: reg_rdata = imr_q;
      SEL_PEND: reg_rdata = iir_q;
      SEL_ENAB: reg_rdata = ier_q;
      default:  reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/igb_checker.sv
module igb_checker #(
  parameter int unsigned DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic [DW-1:0] evt,
  input logic [DW-1:0] src,
  input logic          we,
  input logic [1:0]    idx,
  input logic [DW-1:0] wdata,
  input logic [DW-1:0] imr,
  input logic [DW-1:0] ier,
  input logic [DW-1:0] iir,
  input logic [DW-1:0] isr,
  input logic          irq_any,
  input logic          irq_lo,
  input logic          irq_hi
);
  localparam int unsigned HW = DW / 2;
  logic armed;

  always_ff @(posedge clk) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  // R3
  evt_latch_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    (($past(evt) & ~$past(imr) & ~iir) == '0));

  // R4
  mask_drop_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    ((~$past(iir) & iir & $past(imr)) == '0));

  // R5
  w1c_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    ($past(we) && $past(idx) == 2'd2) |-> ((iir & $past(wdata) & ~$past(evt)) == '0));

  // R7
  mask_wr_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    ($past(we) && $past(idx) == 2'd1) |-> (imr == $past(wdata)));

  // R8
  sum_any_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    irq_any == $past(|(iir & ier)));

  // R9
  sum_lo_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    irq_lo == $past(|(iir[HW-1:0] & ier[HW-1:0])));

  // R9
  sum_hi_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    irq_hi == $past(|(iir[DW-1:HW] & ier[DW-1:HW])));

  // R10
  stat_mirror_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    isr == $past(src));
endmodule

bind intr_group_bank igb_checker #(.DW(DW)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .evt     (evt_i),
  .src     (src_lvl_i),
  .we      (reg_we),
  .idx     (reg_idx),
  .wdata   (reg_wdata),
  .imr     (imr_q),
  .ier     (ier_q),
  .iir     (iir_q),
  .isr     (isr_q),
  .irq_any (irq_any),
  .irq_lo  (irq_lo),
  .irq_hi  (irq_hi)
);

// File: tb/sim_intr_group_bank.sv
module sim_intr_group_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] evt = '0, src = '0, wdata = '0;
  logic        we = 1'b0;
  logic [1:0]  idx = '0;
  logic [31:0] rdata;
  logic        irq_any, irq_lo, irq_hi;

  int checks = 0, fails = 0;
  bit done = 0;

  logic [31:0] m_isr, m_imr, m_iir, m_ier;
  logic        m_any, m_lo, m_hi;

  always #4 clk = ~clk;

  intr_group_bank u0 (
    .clk(clk), .rst_n(rst_n), .evt_i(evt), .src_lvl_i(src),
    .reg_we(we), .reg_idx(idx), .reg_wdata(wdata), .reg_rdata(rdata),
    .irq_any(irq_any), .irq_lo(irq_lo), .irq_hi(irq_hi)
  );

  function automatic logic [31:0] model_read(input logic [1:0] i);
    case (i)
      2'd0: return m_isr;
      2'd1: return m_imr;
      2'd2: return m_iir;
      default: return m_ier;
    endcase
  endfunction

  task automatic chk(input logic [31:0] got, input logic [31:0] exp, input string tag);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  // Called at a negedge: apply inputs, advance model, check at next negedge.
  task automatic step(input logic [31:0] e, input logic [31:0] s, input logic w,
                      input logic [1:0] a, input logic [31:0] d, input logic [1:0] ra,
                      input string tag);
    logic [31:0] n_imr, n_ier, n_iir;
    evt = e; src = s; we = w; idx = a; wdata = d;
    n_imr = (w && a == 2'd1) ? d : m_imr;
    n_ier = (w && a == 2'd3) ? d : m_ier;
    n_iir = (m_iir & ~((w && a == 2'd2) ? d : 32'h0)) | (e & ~m_imr);
    m_any = |(m_iir & m_ier);
    m_lo  = |(m_iir[15:0] & m_ier[15:0]);
    m_hi  = |(m_iir[31:16] & m_ier[31:16]);
    m_isr = s; m_imr = n_imr; m_ier = n_ier; m_iir = n_iir;
    @(posedge clk);
    @(negedge clk);
    evt = '0; we = 1'b0; idx = ra;
    #1;
    chk(rdata, model_read(ra), tag);
    chk({31'b0, irq_any}, {31'b0, m_any}, "R8 irq_any");
    chk({31'b0, irq_lo},  {31'b0, m_lo},  "R9 irq_lo");
    chk({31'b0, irq_hi},  {31'b0, m_hi},  "R9 irq_hi");
  endtask

  initial begin
    void'($urandom(32'd4242));
    m_isr = '0; m_imr = '0; m_iir = '0; m_ier = '0;
    m_any = 0; m_lo = 0; m_hi = 0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R2 reset state
    for (int i = 0; i < 4; i++) begin
      idx = 2'(i); #1;
      chk(rdata, 32'h0, "R2 reset reg");
    end
    chk({29'b0, irq_any, irq_lo, irq_hi}, 32'h0, "R2 reset irq");

    // R1 offsets: mask and enable readback at their indices
    step('0, 32'h0, 1, 2'd1, 32'h0000_00F0, 2'd1, "R1 mask at idx1");
    step('0, 32'h0, 1, 2'd3, 32'h0,         2'd3, "R1 enable at idx3");
    // R4 / R11: masked bits dropped, unmasked latched with enable at zero
    step(32'h0000_00FF, 32'h0, 0, 2'd0, 32'h0, 2'd2, "R4 R11 masked drop");
    chk(rdata, 32'h0000_000F, "R11 pending without enable");
    step('0, 32'h0, 1, 2'd1, 32'h0, 2'd2, "R4 not remembered");
    chk(rdata, 32'h0000_000F, "R4 unmask no replay");
    // R9: enable upper half only, event on bit 20
    step(32'h0010_0000, 32'h0, 1, 2'd3, 32'hFFFF_0000, 2'd2, "R3 bit20 set");
    step('0, 32'h0, 0, 2'd0, 32'h0, 2'd2, "R9 hi only");
    chk({30'b0, irq_lo, irq_hi}, 32'h1, "R9 hi set lo clear");
    // R6: event and clear collide on bit 20
    step(32'h0010_0000, 32'h0, 1, 2'd2, 32'h0010_0001, 2'd2, "R6 collide");
    chk(rdata, 32'h0010_000E, "R6 set wins R5 bit0 cleared");
    // R7: event with same-cycle mask write uses old mask (0)
    step(32'h0000_0100, 32'h0, 1, 2'd1, 32'h0000_0100, 2'd2, "R7 old mask");
    chk(rdata, 32'h0010_010E, "R7 old mask gates");
    // R10: writes to status ignored
    step('0, 32'h0, 1, 2'd0, 32'hFFFF_FFFF, 2'd0, "R10 write ignored");
    chk(rdata, 32'h0, "R10 status unchanged");
    step('0, 32'hA5A5_0F0F, 0, 2'd0, 32'h0, 2'd0, "R10 mirror");
    // R5 clear all
    step('0, 32'h0, 1, 2'd2, 32'hFFFF_FFFF, 2'd2, "R5 clear all");

    // random phase
    for (int n = 0; n < 3000; n++) begin
      logic [1:0] a, ra;
      logic [31:0] d, e;
      a  = 2'($urandom % 4);
      ra = 2'($urandom % 4);
      d  = $urandom;
      if (a == 2'd1) d = d & $urandom & $urandom;
      e  = $urandom & $urandom;
      step(e, $urandom, ($urandom % 3) != 0, a, d, ra,
           ra == 2'd0 ? "R10 rand" : ra == 2'd1 ? "R7 rand" :
           ra == 2'd2 ? "R3 R5 R6 rand" : "R7 R1 rand");
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule